// File: doc/BRIEF.md
# Filtered pin-edge interrupt controller

This block watches the pins of one port and turns qualified level transitions into interrupt and wakeup requests. Each pin is synchronised and passed through its own glitch filter. The filter advances only on a sample strobe, so one filter can run from the fast system clock or from a slow low-power clock. A transition is accepted only after the pin has held its passive level long enough and then its active level long enough. A shorter excursion restarts the count and raises nothing.

Software uses a small register port to set a per-pin enable and a per-pin polarity, and to read and clear sticky per-pin flags. The enabled flags are ORed into one interrupt line and one wakeup line. These lines are shared by the whole port. Each pin also drives a request that keeps the low-power sample clock running. The request stays up only while that pin's filter is still short of a full count and its flag is clear. The OR of all pin requests is also brought out at port level.

Top module: `pin_irq_ctrl`

## Requirements
- R1: After reset, enable, polarity and flags read as zero. `irq_o` and `wake_o` are low, and every bit of `clk_req_o` is high.
- R2: A pin flag is set when at least 4 passive-level samples are followed by 4 active-level samples. A run of 3 or fewer active samples that returns to the passive level sets no flag.
- R3: If fewer than 4 passive samples come before the active samples, no flag is set.
- R4: Polarity bit = 1 makes the high level active, so the rising edge counts. Polarity bit = 0 makes the low level active, so the falling edge counts.
- R5: The filter advances only in cycles with `sample_en` high. With `sample_en` held high, a pin change that completes a valid edge sets the flag at the 6th rising clock edge after the pin changes: two synchroniser stages, then the 4th active sample.
- R6: A pin held at its active level after a detection produces no further flag, even after that flag is cleared.
- R7: Writing to the flag register clears the flags whose write-data bits are 1. Bits written 0 stay unchanged. If a detection and a clear of the same bit fall in the same cycle, the flag stays set.
- R8: `irq_o` and `wake_o` are both high exactly when some flag bit and its enable bit are both 1.
- R9: `clk_req_o[i]` is high when pin i's sample count is at most 4 and its flag is clear. The count stops at 5 during a long passive stretch, and that drops the request. `clk_req_any_o` is the OR of all bits.
- R10: Writing a polarity bit with a new value restarts that pin's filter, so the change of polarity by itself never sets a flag.
- R11: Register addresses are: 0 = enable, 1 = polarity, 2 = flags (write 1 to clear), 3 = reads zero and ignores writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pin_i | input | NUM_PINS | Raw pin levels |
| sample_en | input | 1 | Filter sample strobe |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | NUM_PINS | Register write data |
| reg_rdata | output | NUM_PINS | Register read data, combinational from `reg_addr` |
| irq_o | output | 1 | Shared interrupt request |
| wake_o | output | 1 | Wakeup request |
| clk_req_o | output | NUM_PINS | Per-pin sample-clock request |
| clk_req_any_o | output | 1 | OR of the per-pin clock requests |

## Verification
The bench builds the block with its default values: eight pins, two synchroniser stages and a qualification length of four. This setting puts the exact three-sample and four-sample boundaries in reach, along with the saturation of the count at five. Mixed polarities across the eight pins drive rising and falling edges in one run. Pins held at a level expose the no-repeat rule, the polarity-flip restart and the clock-request drop.

// File: rtl/pin_irq_pkg.sv
// Package: shared types of the filtered pin-edge interrupt controller.
// Assumes a two-bit register address space.
package pin_irq_pkg;

    localparam int ADDR_W = 2;

    // Register selector decoded from the address.
    typedef enum logic [ADDR_W-1:0] {
        SEL_ENABLE = 2'd0,
        SEL_POLAR  = 2'd1,
        SEL_FLAG   = 2'd2,
        SEL_NONE   = 2'd3
    } reg_sel_e;

    // Filter phase: hunting passive samples, or counting active ones.
    typedef enum logic {
        PH_PASSIVE = 1'b0,
        PH_ACTIVE  = 1'b1
    } qual_phase_e;

endpackage

// File: rtl/pin_sync.sv
// Module: multi-stage synchroniser for a vector of asynchronous pins.
// Assumes each bit is independent; there is no cross-bit coherence.
module pin_sync #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    logic [WIDTH-1:0] stage_q [STAGES];

    // Shift the raw levels through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < STAGES; k++) stage_q[k] <= '0;
        end else begin
            stage_q[0] <= din;
            for (int k = 1; k < STAGES; k++) stage_q[k] <= stage_q[k-1];
        end
    end

    assign dout = stage_q[STAGES-1];

endmodule

// File: rtl/edge_qualifier.sv
// Module: per-pin glitch filter. It needs QUAL_LEN passive samples and then
// QUAL_LEN active samples before it emits a one-cycle detect pulse.
// Assumes the level is already synchronised. The passive count saturates
// at QUAL_LEN+1.
module edge_qualifier
    import pin_irq_pkg::*;
#(
    parameter int QUAL_LEN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic smp_en,
    input  logic level,
    input  logic active_high,
    input  logic restart,
    output logic detect,
    output logic busy
);

    localparam int CW = $clog2(QUAL_LEN + 2);
    localparam logic [CW-1:0] QL  = CW'(QUAL_LEN);
    localparam logic [CW-1:0] SAT = CW'(QUAL_LEN + 1);

    qual_phase_e   phase_q, phase_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic          lvl_act;

    assign lvl_act = (level == active_high);

    // Work out the next phase, the next count and the detect pulse.
    always_comb begin
        phase_d = phase_q;
        cnt_d   = cnt_q;
        detect  = 1'b0;
        if (restart) begin
            phase_d = PH_PASSIVE;
            cnt_d   = '0;
        end else if (smp_en) begin
            if (phase_q == PH_PASSIVE) begin
                if (!lvl_act) begin
                    cnt_d = (cnt_q == SAT) ? SAT : cnt_q + 1'b1;
                end else if (cnt_q >= QL) begin
                    if (QUAL_LEN == 1) begin
                        detect = 1'b1;
                        cnt_d  = '0;
                    end else begin
                        phase_d = PH_ACTIVE;
                        cnt_d   = {{(CW-1){1'b0}}, 1'b1};
                    end
                end else begin
                    cnt_d = '0;
                end
            end else begin
                if (lvl_act) begin
                    if (cnt_q == QL - 1'b1) begin
                        detect  = 1'b1;
                        phase_d = PH_PASSIVE;
                        cnt_d   = '0;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end else begin
                    phase_d = PH_PASSIVE;
                    cnt_d   = {{(CW-1){1'b0}}, 1'b1};
                end
            end
        end
    end

    // Hold the filter state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_PASSIVE;
            cnt_q   <= '0;
        end else begin
            phase_q <= phase_d;
            cnt_q   <= cnt_d;
        end
    end

    assign busy = (cnt_q <= QL);

endmodule

// File: rtl/pin_irq_regs.sv
// Module: enable, polarity and sticky flag registers, plus read mux.
// Assumes single-cycle writes; detection beats a clear of the same bit.
module pin_irq_regs
    import pin_irq_pkg::*;
#(
    parameter int NUM_PINS = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                we,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [NUM_PINS-1:0] wdata,
    input  logic [NUM_PINS-1:0] detect,
    output logic [NUM_PINS-1:0] rdata,
    output logic [NUM_PINS-1:0] en_o,
    output logic [NUM_PINS-1:0] pol_o,
    output logic [NUM_PINS-1:0] flags_o,
    output logic [NUM_PINS-1:0] pol_restart
);

    reg_sel_e            sel;
    logic [NUM_PINS-1:0] clr;

    assign sel         = reg_sel_e'(addr);
    assign clr         = (we && sel == SEL_FLAG) ? wdata : '0;
    assign pol_restart = (we && sel == SEL_POLAR) ? (wdata ^ pol_o) : '0;

    // Update the configuration and the sticky flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_o    <= '0;
            pol_o   <= '0;
            flags_o <= '0;
        end else begin
            if (we && sel == SEL_ENABLE) en_o  <= wdata;
            if (we && sel == SEL_POLAR)  pol_o <= wdata;
            flags_o <= (flags_o & ~clr) | detect;
        end
    end

    // Select the read data.
    always_comb begin
        case (sel)
            SEL_ENABLE: rdata = en_o;
            SEL_POLAR:  rdata = pol_o;
            SEL_FLAG:   rdata = flags_o;
            default:    rdata = '0;
        endcase
    end

endmodule

// File: rtl/pin_irq_ctrl.sv
// Module: top of the filtered pin-edge interrupt controller.
// Assumes pin_i is asynchronous and sample_en is a clk-synchronous strobe.
module pin_irq_ctrl
    import pin_irq_pkg::*;
#(
    parameter int NUM_PINS    = 8,
    parameter int SYNC_STAGES = 2,
    parameter int QUAL_LEN    = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] pin_i,
    input  logic                sample_en,
    input  logic                reg_we,
    input  logic [ADDR_W-1:0]   reg_addr,
    input  logic [NUM_PINS-1:0] reg_wdata,
    output logic [NUM_PINS-1:0] reg_rdata,
    output logic                irq_o,
    output logic                wake_o,
    output logic [NUM_PINS-1:0] clk_req_o,
    output logic                clk_req_any_o
);

    logic [NUM_PINS-1:0] sync_lvl;
    logic [NUM_PINS-1:0] detect_w;
    logic [NUM_PINS-1:0] busy_w;
    logic [NUM_PINS-1:0] pol_restart_w;
    logic [NUM_PINS-1:0] en_w;
    logic [NUM_PINS-1:0] pol_w;
    logic [NUM_PINS-1:0] flags_w;

    pin_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (pin_i),
        .dout  (sync_lvl)
    );

    for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
        edge_qualifier #(.QUAL_LEN(QUAL_LEN)) u_qual (
            .clk         (clk),
            .rst_n       (rst_n),
            .smp_en      (sample_en),
            .level       (sync_lvl[g]),
            .active_high (pol_w[g]),
            .restart     (pol_restart_w[g]),
            .detect      (detect_w[g]),
            .busy        (busy_w[g])
        );
    end

    pin_irq_regs #(.NUM_PINS(NUM_PINS)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .we          (reg_we),
        .addr        (reg_addr),
        .wdata       (reg_wdata),
        .detect      (detect_w),
        .rdata       (reg_rdata),
        .en_o        (en_w),
        .pol_o       (pol_w),
        .flags_o     (flags_w),
        .pol_restart (pol_restart_w)
    );

    assign irq_o         = |(flags_w & en_w);
    assign wake_o        = |(flags_w & en_w);
    assign clk_req_o     = busy_w & ~flags_w;
    assign clk_req_any_o = |clk_req_o;

endmodule

// File: rtl/pin_irq_ctrl_chk.sv
// Module: assertion checker bound to pin_irq_ctrl.
// Assumes reset is asserted from time zero.
module pin_irq_ctrl_chk #(
    parameter int NUM_PINS = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic                sample_en,
    input logic                reg_we,
    input logic [1:0]          reg_addr,
    input logic [NUM_PINS-1:0] reg_wdata,
    input logic [NUM_PINS-1:0] pol,
    input logic [NUM_PINS-1:0] en,
    input logic [NUM_PINS-1:0] flags,
    input logic [NUM_PINS-1:0] clk_req,
    input logic                irq
);

    // R5
    flag_needs_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sample_en |=> ((flags & ~$past(flags)) == '0));

    // R7
    flag_clear_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(flags) & ~flags) != '0) |-> ($past(reg_we) && $past(reg_addr) == 2'd2));

    // R9
    clk_req_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_req & flags) == '0);

    // R8
    irq_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($stable(flags) && $stable(en)) |-> $stable(irq));

    // R10
    pol_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == 2'd1) |=>
        ((flags & ~$past(flags) & ($past(reg_wdata) ^ $past(pol))) == '0));

endmodule

bind pin_irq_ctrl pin_irq_ctrl_chk #(.NUM_PINS(NUM_PINS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sample_en (sample_en),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .pol       (pol_w),
    .en        (en_w),
    .flags     (flags_w),
    .clk_req   (clk_req_o),
    .irq       (irq_o)
);

// File: tb/pin_irq_ctrl_tb.sv
// Bench: table-driven edge sequences, then directed tests.
module pin_irq_ctrl_tb;

    localparam int CLK_PERIOD = 10;
    localparam int NV = 10;
    // Entry: {pins, hold cycles, expected flags after the hold}.
    localparam logic [23:0] VEC [NV] = '{
        {8'h00, 8'd8, 8'h00},
        {8'h01, 8'd3, 8'h00},
        {8'h00, 8'd8, 8'h00},   // R2 three-sample pulse filtered
        {8'h01, 8'd4, 8'h00},
        {8'h00, 8'd8, 8'h01},   // R2 exact four-sample pulse accepted
        {8'h10, 8'd8, 8'h01},
        {8'h00, 8'd8, 8'h11},   // R4 falling edge on pin 4
        {8'h02, 8'd8, 8'h13},   // R4 rising edge on pin 1
        {8'hF0, 8'd8, 8'h13},
        {8'h20, 8'd8, 8'hD3}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] pin_i = 8'h00;
    logic       sample_en = 1'b1;
    logic       reg_we = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       irq_o, wake_o, clk_req_any_o;
    logic [7:0] clk_req_o;

    int n_checks = 0;
    int n_err = 0;
    logic [7:0] rv;

    always #(CLK_PERIOD/2) clk = ~clk;

    pin_irq_ctrl u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .pin_i         (pin_i),
        .sample_en     (sample_en),
        .reg_we        (reg_we),
        .reg_addr      (reg_addr),
        .reg_wdata     (reg_wdata),
        .reg_rdata     (reg_rdata),
        .irq_o         (irq_o),
        .wake_o        (wake_o),
        .clk_req_o     (clk_req_o),
        .clk_req_any_o (clk_req_any_o)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        reg_we = 1'b0; reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_err++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic chk_flags(input string tag, input logic [7:0] exp);
        logic [7:0] f;
        rd(2'd2, f);
        chk(tag, f, exp);
    endtask

    task automatic finish_run;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(1);
        // R1 reset state
        rd(2'd0, rv); chk("R1 enable", rv, 8'h00);
        rd(2'd1, rv); chk("R1 polarity", rv, 8'h00);
        chk_flags("R1 flags", 8'h00);
        chk("R1 irq/wake", {6'b0, irq_o, wake_o}, 8'h00);
        chk("R1 clk_req", clk_req_o, 8'hFF);

        wr(2'd0, 8'hFF);
        wr(2'd1, 8'h0F);
        for (int i = 0; i < NV; i++) begin
            pin_i = VEC[i][23:16];
            tick(int'(VEC[i][15:8]));
            chk_flags($sformatf("R2/R4 vector %0d flags", i), VEC[i][7:0]);
            chk($sformatf("R8 vector %0d irq", i), {7'b0, irq_o}, {7'b0, VEC[i][7:0] != 8'h00});
        end

        // R8 enable masking
        wr(2'd0, 8'h00);
        chk("R8 masked irq/wake", {6'b0, irq_o, wake_o}, 8'h00);
        wr(2'd0, 8'h02);
        chk("R8 pin1 irq/wake", {6'b0, irq_o, wake_o}, 8'h03);
        wr(2'd0, 8'h04);
        chk("R8 pin2 no flag", {6'b0, irq_o, wake_o}, 8'h00);

        // R7 write-one-to-clear
        wr(2'd2, 8'h00);
        chk_flags("R7 zero write", 8'hD3);
        wr(2'd2, 8'h03);
        chk_flags("R7 clear bits 0,1", 8'hD0);
        // R6 held active level, no re-flag
        wr(2'd2, 8'hC0);
        tick(10);
        chk_flags("R6 no repeat", 8'h10);

        // R11 register map
        rd(2'd3, rv); chk("R11 addr3", rv, 8'h00);
        rd(2'd0, rv); chk("R11 enable", rv, 8'h04);
        rd(2'd1, rv); chk("R11 polarity", rv, 8'h0F);

        // R3 short passive stretch
        pin_i = 8'h21; tick(8);
        chk_flags("R3 setup", 8'h11);
        wr(2'd2, 8'h01);
        pin_i = 8'h20; tick(3);
        pin_i = 8'h21; tick(10);
        chk_flags("R3 three passive samples", 8'h10);

        // R7 detection beats clear
        pin_i = 8'h20; tick(8);
        pin_i = 8'h21; tick(8);
        chk_flags("R7 setup", 8'h11);
        pin_i = 8'h20; tick(8);
        pin_i = 8'h21; tick(5);
        wr(2'd2, 8'h01);
        chk_flags("R7 detect wins", 8'h11);
        tick(4);
        wr(2'd2, 8'h01);
        chk_flags("R7 plain clear", 8'h10);

        // R10 polarity flip restarts filter
        wr(2'd1, 8'h2F);
        tick(10);
        chk_flags("R10 no flag from flip", 8'h10);
        pin_i = 8'h00; tick(8);
        pin_i = 8'h20; tick(8);
        chk_flags("R4 rising on pin5", 8'h30);

        // R5 sample gating and latency
        pin_i = 8'h00; tick(8);
        sample_en = 1'b0;
        pin_i = 8'h04; tick(10);
        chk_flags("R5 gated off", 8'h30);
        pin_i = 8'h00; tick(2);
        sample_en = 1'b1; tick(8);
        pin_i = 8'h04; tick(5);
        chk_flags("R5 before 6th edge", 8'h30);
        tick(1);
        chk_flags("R5 at 6th edge", 8'h34);

        // R9 clock request
        chk("R9 held active pins", clk_req_o, 8'hC0);
        wr(2'd2, 8'h10);
        chk("R9 flag cleared", clk_req_o, 8'hD0);
        pin_i = 8'hF4; tick(10);
        chk("R9 saturated", clk_req_o, 8'h00);
        chk("R9 any low", {7'b0, clk_req_any_o}, 8'h00);
        pin_i = 8'hE4; tick(3);
        chk("R9 mid qualify", clk_req_o, 8'h10);
        chk("R9 any high", {7'b0, clk_req_any_o}, 8'h01);
        tick(5);
        chk("R9 after flag", clk_req_o, 8'h00);

        finish_run();
    end

endmodule